// File: doc/BRIEF.md
# Receive Queue with Fill Trigger and Idle Timeout

This block is the receive-side holding queue of a serial port. The serial receiver pushes each character, together with three error marks (parity, framing, line break), into a 16-entry first-in first-out store. The host drains the queue one entry at a time through a pop strobe and reads the oldest character and its marks at the head outputs. The marks of a character are shown only once that character reaches the head. A separate flag reports whether any stored character carries a mark at all.

Two requests help the host pace its reads. The fill request is raised while the number of stored entries is at or above a level picked by a 2-bit select. The idle timeout is raised when characters wait in the queue and nothing has been pushed or popped for four character times, as counted on a character-time tick input. A configuration write carries an enable bit, a clear bit and the level select. The clear and the new select take effect only when that write has its enable bit set. A push into a full queue is dropped and reported by a one-cycle overrun pulse.

Top module: `rxq_trig_fifo`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `count_o`=0, `full_o`=0), the level select is 00, and `trig_o`, `timeout_o`, `overrun_o` and `err_any_o` are 0.
- R2: Entries leave in the order they were pushed. `head_data_o` shows the oldest entry, or 0 when the queue is empty. `count_o` follows every accepted push and pop in the cycle after the clock edge. `full_o` is 1 at 16 entries and `empty_o` is 1 at 0 entries.
- R3: A push into a full queue without a pop in the same cycle is discarded and the stored entries are unchanged. `overrun_o` is 1 for exactly the one cycle after that edge. A push and a pop in the same cycle on a full queue are both accepted, and no overrun is raised.
- R4: `trig_o` is 1 exactly while `count_o` is at or above the selected level. Select 00 gives 1 entry, 01 gives 4, 10 gives 8 and 11 gives 14.
- R5: A configuration write (`cfg_we_i`=1) with `cfg_en_i`=0 changes neither the level select nor the queue contents, even when `cfg_clr_i`=1.
- R6: A configuration write with `cfg_en_i`=1 and `cfg_clr_i`=1 empties the queue by the next cycle. It takes precedence over a push or a pop in the same cycle, which are dropped without an overrun. It also clears the timeout and the error flag.
- R7: `head_pe_o`, `head_fe_o` and `head_bi_o` show the parity, framing and break marks of the head entry only. They are 0 when the queue is empty.
- R8: `err_any_o` is 1 exactly while at least one stored entry has any of its three marks set.
- R9: The idle counter advances on each `char_tick_i` while the queue holds data, and restarts on every accepted push or pop and on a clear. `timeout_o` is 1 once four ticks have been counted, and it stays 1 until a push, a pop or a clear. It is never 1 while the queue is empty.
- R10: A pop on an empty queue is ignored: the count stays 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Receiver delivers one character |
| push_data_i | input | 8 | Character being pushed |
| push_pe_i | input | 1 | Parity mark of the pushed character |
| push_fe_i | input | 1 | Framing mark of the pushed character |
| push_bi_i | input | 1 | Break mark of the pushed character |
| pop_i | input | 1 | Host removes the head entry |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit of the configuration write; gates clear and select |
| cfg_clr_i | input | 1 | Clear request of the configuration write |
| cfg_lvl_i | input | 2 | Fill level select (00:1, 01:4, 10:8, 11:14) |
| char_tick_i | input | 1 | One pulse per character time |
| head_data_o | output | 8 | Oldest stored character |
| head_pe_o | output | 1 | Parity mark of the head entry |
| head_fe_o | output | 1 | Framing mark of the head entry |
| head_bi_o | output | 1 | Break mark of the head entry |
| err_any_o | output | 1 | Some stored entry carries a mark |
| count_o | output | 5 | Number of stored entries |
| full_o | output | 1 | Queue holds 16 entries |
| empty_o | output | 1 | Queue holds no entry |
| trig_o | output | 1 | Fill level reached |
| timeout_o | output | 1 | Data has been waiting four character times |
| overrun_o | output | 1 | One-cycle pulse: a push was dropped on a full queue |

## Verification
The hardest cases to reach from the ports sit at the full boundary. One is a push alone into a full queue, which must be dropped. The other is a push paired with a pop, which must be accepted. A third case is a clear arriving together with a push. The stimulus fills the queue to exactly 16 entries with directed pushes and then issues each of these combinations on purpose. The timeout needs four ticks with no push and no pop, so it is reached only with directed idle gaps. A long random phase follows, with bursts that favour pushes and bursts that favour pops, so the queue passes through full and empty many times while a behavioural model is compared on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic pe;
    logic fe;
    logic bi;
  } rxq_tag_t;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg #(
  parameter int LVL0 = 1,
  parameter int LVL1 = 4,
  parameter int LVL2 = 8,
  parameter int LVL3 = 14,
  parameter int CW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [1:0]    sel_i,
  output logic          clr_o,
  output logic [CW-1:0] level_o
);
  logic [1:0] sel_q;
  logic       apply;

  assign apply = we_i & en_i;
  assign clr_o = apply & clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= 2'b00;
    else if (apply) sel_q <= sel_i;
  end

  always_comb begin
    unique case (sel_q)
      2'b00:   level_o = CW'(LVL0);
      2'b01:   level_o = CW'(LVL1);
      2'b10:   level_o = CW'(LVL2);
      default: level_o = CW'(LVL3);
    endcase
  end

  assert_sel_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !en_i) |=> (sel_q == $past(sel_q)))
    else $error("select changed on write without enable");
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  rxq_tag_t      push_tag_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [DW-1:0] head_data_o,
  output rxq_tag_t      head_tag_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_acc_o,
  output logic          pop_acc_o,
  output logic          overrun_o
);
  logic [DW-1:0] data_q [DEPTH];
  rxq_tag_t      tag_q  [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          ovr_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o     = (count_q == CW'(DEPTH));
  assign empty_o    = (count_q == '0);
  assign pop_acc_o  = pop_i & ~empty_o & ~clr_i;
  // a pop frees a slot in the same cycle, so push on full is still accepted
  assign push_acc_o = push_i & ~clr_i & (~full_o | pop_acc_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else if (push_acc_o) begin
      data_q[wr_q] <= push_data_i;
      tag_q[wr_q]  <= push_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= push_i & ~clr_i & full_o & ~pop_acc_o;
      if (clr_i) begin
        wr_q    <= '0;
        rd_q    <= '0;
        count_q <= '0;
      end else begin
        if (push_acc_o) wr_q <= ptr_next(wr_q);
        if (pop_acc_o)  rd_q <= ptr_next(rd_q);
        unique case ({push_acc_o, pop_acc_o})
          2'b10:   count_q <= count_q + CW'(1);
          2'b01:   count_q <= count_q - CW'(1);
          default: count_q <= count_q;
        endcase
      end
    end
  end

  assign count_o     = count_q;
  assign overrun_o   = ovr_q;
  assign head_data_o = empty_o ? '0 : data_q[rd_q];
  assign head_tag_o  = empty_o ? '0 : tag_q[rd_q];

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH))
    else $error("count above depth");

  assert_drop_on_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> (full_o && overrun_o))
    else $error("push on full not dropped with overrun");

  assert_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> (empty_o && !overrun_o))
    else $error("pop on empty changed state");

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !overrun_o))
    else $error("clear did not empty queue");
endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_acc_i,
  input  logic          push_err_i,
  input  logic          pop_acc_i,
  input  logic          pop_err_i,
  input  logic [CW-1:0] fill_i,
  output logic          any_o
);
  logic [CW-1:0] err_q;
  logic          inc, dec;

  assign inc = push_acc_i & push_err_i;
  assign dec = pop_acc_i & pop_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= '0;
    else if (clr_i)       err_q <= '0;
    else if (inc && !dec) err_q <= err_q + CW'(1);
    else if (dec && !inc) err_q <= err_q - CW'(1);
  end

  assign any_o = (err_q != '0);

  assert_err_within_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q <= fill_i)
    else $error("more marked entries than stored entries");
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TO_CHARS = 4,
  parameter int TW       = $clog2(TO_CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic has_data_i,
  input  logic tick_i,
  output logic timeout_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (restart_i || !has_data_i)       cnt_q <= '0;
    else if (tick_i && cnt_q != TW'(TO_CHARS)) cnt_q <= cnt_q + TW'(1);
  end

  assign timeout_o = (cnt_q == TW'(TO_CHARS));

  assert_to_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !timeout_o)
    else $error("timeout survived push, pop or clear");

  assert_to_rise_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(tick_i))
    else $error("timeout rose without a tick");
endmodule

// File: rtl/rxq_trig_fifo.sv
module rxq_trig_fifo
  import rxq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  parameter int LVL0     = 1,
  parameter int LVL1     = 4,
  parameter int LVL2     = 8,
  parameter int LVL3     = 14,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_pe_i,
  input  logic          push_fe_i,
  input  logic          push_bi_i,
  input  logic          pop_i,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic          cfg_clr_i,
  input  logic [1:0]    cfg_lvl_i,
  input  logic          char_tick_i,
  output logic [DW-1:0] head_data_o,
  output logic          head_pe_o,
  output logic          head_fe_o,
  output logic          head_bi_o,
  output logic          err_any_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          trig_o,
  output logic          timeout_o,
  output logic          overrun_o
);
  rxq_tag_t      push_tag, head_tag;
  logic          clr, push_acc, pop_acc;
  logic [CW-1:0] level, count;

  assign push_tag = '{pe: push_pe_i, fe: push_fe_i, bi: push_bi_i};

  rxq_cfg #(.LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .CW(CW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .en_i(cfg_en_i), .clr_i(cfg_clr_i), .sel_i(cfg_lvl_i),
    .clr_o(clr), .level_o(level)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i, .push_data_i, .push_tag_i(push_tag),
    .pop_i, .clr_i(clr),
    .head_data_o, .head_tag_o(head_tag),
    .count_o(count), .full_o, .empty_o,
    .push_acc_o(push_acc), .pop_acc_o(pop_acc), .overrun_o
  );

  rxq_err_track #(.CW(CW)) u_err (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_acc_i(push_acc), .push_err_i(|push_tag),
    .pop_acc_i(pop_acc), .pop_err_i(|head_tag),
    .fill_i(count), .any_o(err_any_o)
  );

  rxq_idle_timer #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk_i, .rst_ni,
    .restart_i(push_acc | pop_acc | clr),
    .has_data_i(~empty_o), .tick_i(char_tick_i),
    .timeout_o
  );

  assign count_o   = count;
  assign head_pe_o = head_tag.pe;
  assign head_fe_o = head_tag.fe;
  assign head_bi_o = head_tag.bi;
  assign trig_o    = (count >= level);

  assert_trig_needs_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !empty_o)
    else $error("fill request on empty queue");

  assert_to_needs_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !empty_o)
    else $error("timeout on empty queue");

  assert_err_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !err_any_o)
    else $error("error flag on empty queue");
endmodule

// File: tb/rxq_trig_fifo_test.sv
`timescale 1ns/1ps
module rxq_trig_fifo_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       push = 0, pop = 0, pe = 0, fe = 0, bi = 0;
  logic [7:0] din = 0;
  logic       cfg_we = 0, cfg_en = 0, cfg_clr = 0, tick = 0;
  logic [1:0] cfg_lvl = 0;
  logic [7:0] head;
  logic       hpe, hfe, hbi, err_any, full, empty, trig, tmo, ovr;
  logic [4:0] count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxq_trig_fifo uut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push), .push_data_i(din), .push_pe_i(pe), .push_fe_i(fe), .push_bi_i(bi),
    .pop_i(pop), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_clr_i(cfg_clr), .cfg_lvl_i(cfg_lvl),
    .char_tick_i(tick),
    .head_data_o(head), .head_pe_o(hpe), .head_fe_o(hfe), .head_bi_o(hbi),
    .err_any_o(err_any), .count_o(count), .full_o(full), .empty_o(empty),
    .trig_o(trig), .timeout_o(tmo), .overrun_o(ovr)
  );

  // reference model: entry = {pe, fe, bi, data}
  logic [10:0] q[$];
  int m_sel, m_idle;
  bit m_ovr;

  function automatic int lvl_of(int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_sel = 0; m_idle = 0; m_ovr = 0;
    end else begin
      bit ap, ps;
      if (cfg_we && cfg_en) m_sel = cfg_lvl;
      m_ovr = 0;
      if (cfg_we && cfg_en && cfg_clr) begin
        q.delete(); m_idle = 0;
      end else begin
        ap = pop && q.size() > 0;
        ps = push && (q.size() < 16 || ap);
        if (push && !ps) m_ovr = 1;
        if (q.size() == 0 || ap || ps) m_idle = 0;
        else if (tick && m_idle < 4) m_idle++;
        if (ap) void'(q.pop_front());
        if (ps) q.push_back({pe, fe, bi, din});
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n, e_head, e_tag, e_any;
      n = q.size();
      e_head = (n > 0) ? int'(q[0][7:0]) : 0;
      e_tag  = (n > 0) ? int'(q[0][10:8]) : 0;
      e_any  = 0;
      foreach (q[i]) if (q[i][10:8] != 0) e_any = 1;
      chk(count == n, "R2", "count", count, n);
      chk(empty == (n == 0), "R2", "empty", empty, n == 0);
      chk(full == (n == 16), "R2", "full", full, n == 16);
      chk(head == e_head, "R2", "head data", head, e_head);
      chk({hpe, hfe, hbi} == e_tag, "R7", "head marks", {hpe, hfe, hbi}, e_tag);
      chk(err_any == e_any, "R8", "err_any", err_any, e_any);
      chk(trig == (n >= lvl_of(m_sel)), "R4", "trig", trig, n >= lvl_of(m_sel));
      chk(tmo == (m_idle == 4), "R9", "timeout", tmo, m_idle == 4);
      chk(ovr == m_ovr, "R3", "overrun", ovr, m_ovr);
    end
  end

  task automatic step(input bit p_push, input int d, input int tags, input bit p_pop, input bit p_tick);
    push = p_push; din = 8'(d); {pe, fe, bi} = 3'(tags); pop = p_pop; tick = p_tick;
    @(negedge clk);
    push = 0; pop = 0; tick = 0; {pe, fe, bi} = 0;
  endtask

  task automatic cfg(input bit en, input bit clr, input int lvl, input bit p_push);
    cfg_we = 1; cfg_en = en; cfg_clr = clr; cfg_lvl = 2'(lvl); push = p_push; din = 8'hEE;
    @(negedge clk);
    cfg_we = 0; cfg_en = 0; cfg_clr = 0; push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(empty && count == 0 && !full, "R1", "reset fill", count, 0);
    chk(!trig && !tmo && !ovr && !err_any, "R1", "reset flags", {trig, tmo, ovr, err_any}, 0);
    // R10 pop on empty
    step(0, 0, 0, 1, 0);
    chk(empty && !ovr, "R10", "pop on empty", count, 0);
    // R4 level 01 -> 4
    cfg(1, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 8'h10 + i, 0, 0, 0);
    chk(!trig, "R4", "3 below level 4", trig, 0);
    step(1, 8'h13, 0, 0, 0);
    chk(trig, "R4", "4 at level 4", trig, 1);
    // R5 disabled write: no clear, no select change
    cfg(0, 1, 3, 0);
    chk(count == 4 && trig, "R5", "write without enable", count, 4);
    // R2 order
    for (int i = 0; i < 4; i++) begin
      chk(head == 8'h10 + i, "R2", "order", head, 8'h10 + i);
      step(0, 0, 0, 1, 0);
    end
    // R7/R8 marks surface at head
    cfg(1, 0, 3, 0);
    step(1, 8'h21, 0, 0, 0);
    step(1, 8'h22, 3'b100, 0, 0);
    step(1, 8'h23, 3'b001, 0, 0);
    chk(err_any && !hpe && !hbi, "R7", "mark hidden behind head", {hpe, hfe, hbi}, 0);
    step(0, 0, 0, 1, 0);
    chk(hpe && !hbi, "R7", "parity mark at head", {hpe, hfe, hbi}, 4);
    step(0, 0, 0, 1, 0);
    chk(hbi && err_any, "R8", "break mark at head", {hpe, hfe, hbi}, 1);
    step(0, 0, 0, 1, 0);
    chk(!err_any, "R8", "no marks left", err_any, 0);
    // R9 timeout
    step(1, 8'h31, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0); end
    chk(!tmo, "R9", "three ticks", tmo, 0);
    step(0, 0, 0, 0, 1);
    chk(tmo, "R9", "four ticks", tmo, 1);
    step(1, 8'h32, 0, 0, 0);
    chk(!tmo, "R9", "push restarts", tmo, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
    chk(tmo, "R9", "timeout again", tmo, 1);
    step(0, 0, 0, 1, 0);
    chk(!tmo, "R9", "pop clears", tmo, 0);
    // R3 fill to 16, overrun, push+pop on full
    for (int i = 0; i < 15; i++) step(1, 8'h40 + i, 0, 0, 0);
    chk(full && trig, "R3", "full at 16", count, 16);
    step(1, 8'hAA, 3'b010, 0, 0);
    chk(ovr && full && !err_any, "R3", "dropped push", ovr, 1);
    @(negedge clk);
    chk(!ovr, "R3", "overrun one cycle", ovr, 0);
    step(1, 8'h55, 0, 1, 0);
    chk(full && !ovr && head == 8'h40, "R3", "push+pop on full", head, 8'h40);
    // R6 clear wins over push
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    cfg(1, 1, 0, 1);
    chk(empty && !tmo && !ovr && !trig, "R6", "clear with push", count, 0);
    // random phase
    for (int b = 0; b < 60; b++) begin
      int pw = (b % 2) ? 75 : 35;
      for (int c = 0; c < 50; c++) begin
        bit rp = ($urandom % 100) < pw;
        bit rq = ($urandom % 100) < (100 - pw);
        bit rt = ($urandom % 4) == 0;
        if (($urandom % 100) == 0) cfg($urandom % 2, ($urandom % 3) == 0, $urandom % 4, rp);
        else step(rp, $urandom % 256, ($urandom % 4 == 0) ? $urandom % 8 : 0, rq, rt);
      end
      repeat (6) step(0, 0, 0, 0, 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule